// File: doc/BRIEF.md
# SDRAM Bank Command Legality Checker

This block sits beside the command bus of a single-data-rate mobile SDRAM and watches it on every rising clock edge. It decodes the clock-enable, chip-select, row-strobe, column-strobe, write-enable, bank-address and A10 pins into one command. It then follows every bank through idle, opening, open, read burst, write burst and closing. It also follows the device through deep power-down. Any command that the addressed bank cannot accept in its present state, or that arrives before its timing window has run out, produces a one-cycle violation pulse with a reason code.

A rejected command changes nothing. Each bank's state is brought out as a 3-bit code so that a bench or a monitor can follow the tracker directly. The row-precharge delay, the activate-to-column delay and the burst length are parameters counted in clock cycles. The number of banks is also a parameter.

Top module: `sdram_cmd_checker`

## Requirements
- R1: With CKE high, a cycle with cs_n high (inhibit) or with cs_n low and ras_n, cas_n, we_n all high (NOP) raises no violation and leaves every bank to continue its timers and bursts. Command codes {cs_n,ras_n,cas_n,we_n}: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000, BURST TERMINATE 0110.
- R2: In an idle bank (bank_state code 0), ACTIVE and PRECHARGE are accepted. READ, WRITE and BURST TERMINATE give reason 1 (illegal command). Reason codes: 0 none, 1 illegal command, 2 precharge delay not met, 3 activate delay not met, 4 power-down entry while busy.
- R3: An accepted ACTIVE puts the bank in opening (code 1). It becomes open (code 2) T_RCD cycles after the ACTIVE. A READ or WRITE issued before that gives reason 3.
- R4: In an open bank, READ starts a read burst (code 3), WRITE starts a write burst (code 4) and PRECHARGE starts closing (code 5). ACTIVE to an open bank gives reason 1.
- R5: During a read burst, READ restarts the burst, WRITE switches it to a write burst, PRECHARGE cuts it short and starts closing, and BURST TERMINATE returns the bank to open. ACTIVE gives reason 1.
- R6: During a write burst, READ, WRITE, PRECHARGE and BURST TERMINATE behave as in R5.
- R7: A burst that is not interrupted returns its bank to open BURST_LEN cycles after its READ or WRITE.
- R8: A closing bank becomes idle T_RP cycles after the PRECHARGE. An ACTIVE issued before that gives reason 2. PRECHARGE with a10 high addresses every bank. PRECHARGE to a bank that is still opening gives reason 1.
- R9: AUTO REFRESH and LOAD MODE are accepted only when every bank is idle. Otherwise they give reason 2 if any bank is closing, and reason 1 if none is.
- R10: With CKE low, the pattern cs_n=0, ras_n=1, cas_n=1, we_n=0 requests deep power-down. If every bank is idle, dpd_active rises after that edge. If not, the request gives reason 4 and power-down is not entered.
- R11: While in power-down, every command is ignored, and the first edge with CKE high clears dpd_active. Outside power-down, any edge with CKE low other than an entry request is ignored.
- R12: violation and reason are registered at the edge that samples the command and hold for exactly that one cycle. reason is non-zero exactly when violation is high. A rejected command leaves every bank state unchanged. After reset, all banks are idle, with no violation and no power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock; commands sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable pin of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10; selects all banks for PRECHARGE |
| violation | output | 1 | One-cycle pulse for a rejected command |
| reason | output | 3 | Reason code for the pulse, 0 otherwise |
| bank_state | output | NUM_BANKS*3 | 3-bit state code of each bank, bank 0 in the low bits |
| dpd_active | output | 1 | High while the device is in deep power-down |

## Verification
The assertions assume that every command pin holds a known value from the first edge after reset onwards, and that reset is held for more than one clock. Their checks on power-down entry look one cycle into the past, so that past cycle must lie after reset. The timing parameters are also assumed to be at least one. The stimulus drives every pin to a defined level before reset is released and changes pins only on falling edges. It holds reset for three cycles and keeps the parameters at small values of two to four cycles, so that every transient state and every early-command case is reached.

// File: rtl/sdram_chk_pkg.sv
// Package: shared command, bank-state and reason encodings for the
// SDRAM command legality checker. Assumes 3-bit state and reason codes.
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        C_IGNORE  = 4'd0,
        C_INHIBIT = 4'd1,
        C_NOP     = 4'd2,
        C_ACT     = 4'd3,
        C_READ    = 4'd4,
        C_WRITE   = 4'd5,
        C_PRE     = 4'd6,
        C_PREALL  = 4'd7,
        C_REF     = 4'd8,
        C_LMR     = 4'd9,
        C_BST     = 4'd10,
        C_DPD     = 4'd11
    } cmd_e;

    typedef enum logic [2:0] {
        B_IDLE    = 3'd0,
        B_OPENING = 3'd1,
        B_OPEN    = 3'd2,
        B_READ    = 3'd3,
        B_WRITE   = 3'd4,
        B_CLOSING = 3'd5
    } bank_st_e;

    typedef enum logic [2:0] {
        V_NONE     = 3'd0,
        V_ILLEGAL  = 3'd1,
        V_TRP      = 3'd2,
        V_TRCD     = 3'd3,
        V_DPD_BUSY = 3'd4
    } reason_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Module: sdram_cmd_decode
// Turns the raw command pins sampled at one edge into a single command.
// Assumes: pins are stable around the rising edge. With CKE low, only
// the power-down entry pattern is recognised; everything else is ignored.
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_e cmd
);

    // Purpose: map the pin pattern onto the command enumeration.
    always_comb begin
        cmd = C_IGNORE;
        if (!cke) begin
            if (!cs_n && ras_n && cas_n && !we_n) begin
                cmd = C_DPD;
            end
        end else if (cs_n) begin
            cmd = C_INHIBIT;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = C_NOP;
                3'b011:  cmd = C_ACT;
                3'b101:  cmd = C_READ;
                3'b100:  cmd = C_WRITE;
                3'b010:  cmd = a10 ? C_PREALL : C_PRE;
                3'b001:  cmd = C_REF;
                3'b000:  cmd = C_LMR;
                3'b110:  cmd = C_BST;
                default: cmd = C_IGNORE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
// Module: sdram_bank_track
// Follows one bank through idle, opening, open, read/write burst and
// closing. It judges any bank-addressed command against the present state
// and applies it only when the top level commits the whole command.
// Assumes: T_RP, T_RCD and BURST_LEN are at least 1; hit is high only
// for bank-addressed commands (ACT, READ, WRITE, PRE, PREALL, BST).
module sdram_bank_track
    import sdram_chk_pkg::*;
#(
    parameter int T_RP      = 3,
    parameter int T_RCD     = 2,
    parameter int BURST_LEN = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_e     cmd,
    input  logic     hit,
    input  logic     commit,
    output bank_st_e state,
    output reason_e  verdict
);

    localparam int LONG_A  = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int LONGEST = (LONG_A > BURST_LEN) ? LONG_A : BURST_LEN;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] BL_LOAD  = CNT_W'(BURST_LEN - 1);

    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] nxt_rem;
    bank_st_e         nxt_state;

    // Purpose: state each transient state settles into when its timer ends.
    function automatic bank_st_e settle(input bank_st_e s);
        case (s)
            B_CLOSING: settle = B_IDLE;
            default:   settle = B_OPEN;
        endcase
    endfunction

    // Purpose: judge a command addressed to this bank against its state.
    always_comb begin
        verdict = V_NONE;
        if (hit) begin
            case (cmd)
                C_ACT: begin
                    if (state == B_CLOSING)   verdict = V_TRP;
                    else if (state != B_IDLE) verdict = V_ILLEGAL;
                end
                C_READ, C_WRITE: begin
                    if (state == B_OPENING) verdict = V_TRCD;
                    else if (!(state inside {B_OPEN, B_READ, B_WRITE})) verdict = V_ILLEGAL;
                end
                C_PRE, C_PREALL: begin
                    if (state == B_OPENING) verdict = V_ILLEGAL;
                end
                C_BST: begin
                    if (!(state inside {B_READ, B_WRITE})) verdict = V_ILLEGAL;
                end
                default: verdict = V_NONE;
            endcase
        end
    end

    // Purpose: next state from the running timer, or from a committed command.
    always_comb begin
        nxt_state = state;
        nxt_rem   = rem;
        if (state inside {B_OPENING, B_CLOSING, B_READ, B_WRITE}) begin
            if (rem <= CNT_W'(1)) begin
                nxt_state = settle(state);
                nxt_rem   = '0;
            end else begin
                nxt_rem = rem - CNT_W'(1);
            end
        end
        if (hit && commit) begin
            case (cmd)
                C_ACT: begin
                    nxt_state = (T_RCD > 1) ? B_OPENING : B_OPEN;
                    nxt_rem   = RCD_LOAD;
                end
                C_READ: begin
                    nxt_state = (BURST_LEN > 1) ? B_READ : B_OPEN;
                    nxt_rem   = BL_LOAD;
                end
                C_WRITE: begin
                    nxt_state = (BURST_LEN > 1) ? B_WRITE : B_OPEN;
                    nxt_rem   = BL_LOAD;
                end
                C_PRE, C_PREALL: begin
                    if (state inside {B_OPEN, B_READ, B_WRITE}) begin
                        nxt_state = (T_RP > 1) ? B_CLOSING : B_IDLE;
                        nxt_rem   = RP_LOAD;
                    end
                end
                C_BST: begin
                    nxt_state = B_OPEN;
                    nxt_rem   = '0;
                end
                default: ;
            endcase
        end
    end

    // Purpose: hold the bank state and its timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= B_IDLE;
            rem   <= '0;
        end else begin
            state <= nxt_state;
            rem   <= nxt_rem;
        end
    end

    // A bank can only start opening from idle (R3).
    p_open_needs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != B_IDLE && state != B_OPENING) |=> (state != B_OPENING));

    // A burst can only start from an open row or another burst (R4).
    p_burst_needs_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {B_IDLE, B_OPENING, B_CLOSING}) |=> !(state inside {B_READ, B_WRITE}));

    // Idle is reached only through closing when the precharge delay exceeds one cycle (R8).
    p_idle_via_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((T_RP > 1) && state != B_IDLE && state != B_CLOSING) |=> (state != B_IDLE));

endmodule

// File: rtl/sdram_cmd_checker.sv
// Module: sdram_cmd_checker (top)
// Decodes the SDRAM command bus, drives one tracker per bank, applies the
// device-wide rules (refresh, mode load, deep power-down) and reports the
// first reason a command is rejected as a registered one-cycle pulse.
// Assumes: NUM_BANKS is a power of two of at least 2; a rejected command
// is dropped as a whole, so no bank changes state on it.
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    parameter  int T_RP      = 3,
    parameter  int T_RCD     = 2,
    parameter  int BURST_LEN = 4,
    localparam int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic                   a10,
    output logic                   violation,
    output logic [2:0]             reason,
    output logic [NUM_BANKS*3-1:0] bank_state,
    output logic                   dpd_active
);

    cmd_e     dec_cmd;
    cmd_e     eff_cmd;
    bank_st_e st       [NUM_BANKS];
    reason_e  verdicts [NUM_BANKS];
    logic     hits     [NUM_BANKS];
    reason_e  dev_reason;
    reason_e  first_reason;
    logic     commit;
    logic     all_idle;
    logic     any_closing;
    logic     dpd_q;

    sdram_cmd_decode u_decode (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (a10),
        .cmd   (dec_cmd)
    );

    // Purpose: mask every command while the device sleeps.
    assign eff_cmd = dpd_q ? C_IGNORE : dec_cmd;

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        assign hits[gi] = (eff_cmd == C_PREALL) ||
                          ((eff_cmd inside {C_ACT, C_READ, C_WRITE, C_PRE, C_BST}) &&
                           (ba == BA_W'(gi)));

        sdram_bank_track #(
            .T_RP      (T_RP),
            .T_RCD     (T_RCD),
            .BURST_LEN (BURST_LEN)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (eff_cmd),
            .hit     (hits[gi]),
            .commit  (commit),
            .state   (st[gi]),
            .verdict (verdicts[gi])
        );

        assign bank_state[gi*3 +: 3] = st[gi];
    end

    // Purpose: summarise the banks for the device-wide rules.
    always_comb begin
        all_idle    = 1'b1;
        any_closing = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (st[i] != B_IDLE)    all_idle    = 1'b0;
            if (st[i] == B_CLOSING) any_closing = 1'b1;
        end
    end

    // Purpose: judge the commands that need every bank idle.
    always_comb begin
        dev_reason = V_NONE;
        case (eff_cmd)
            C_REF, C_LMR: if (!all_idle) dev_reason = any_closing ? V_TRP : V_ILLEGAL;
            C_DPD:        if (!all_idle) dev_reason = V_DPD_BUSY;
            default:      dev_reason = V_NONE;
        endcase
    end

    // Purpose: pick the device reason, else the lowest-numbered bank's reason.
    always_comb begin
        first_reason = dev_reason;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (first_reason == V_NONE && verdicts[i] != V_NONE) first_reason = verdicts[i];
        end
        commit = (first_reason == V_NONE);
    end

    // Purpose: register the violation pulse and its reason.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            violation <= 1'b0;
            reason    <= 3'd0;
        end else begin
            violation <= (first_reason != V_NONE);
            reason    <= first_reason;
        end
    end

    // Purpose: enter deep power-down from all-idle, leave it on CKE high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dpd_q <= 1'b0;
        end else if (dpd_q) begin
            if (cke) dpd_q <= 1'b0;
        end else if (eff_cmd == C_DPD && all_idle) begin
            dpd_q <= 1'b1;
        end
    end

    assign dpd_active = dpd_q;

    // A pulse always carries a code and a code never appears without one (R12).
    p_flag_has_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (reason != 3'd0));
    p_code_needs_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !violation |-> (reason == 3'd0));

    // Power-down is entered only from an all-idle device (R10).
    p_dpd_entry_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dpd_active) |-> $past(all_idle));

    // While asleep every bank stays idle, and CKE high wakes the device (R11).
    p_dpd_banks_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_active |-> all_idle);
    p_dpd_exit_cke_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dpd_active && cke) |=> !dpd_active);

endmodule

// File: tb/sdram_cmd_checker_bench.sv
module sdram_cmd_checker_bench;

    localparam int NB    = 4;
    localparam int BA_W  = 2;
    localparam int T_RP  = 3;
    localparam int T_RCD = 2;
    localparam int BL    = 4;

    localparam int S_IDLE = 0, S_OPENING = 1, S_OPEN = 2, S_READ = 3, S_WRITE = 4, S_CLOSING = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            cke   = 1'b1;
    logic            cs_n  = 1'b1;
    logic            ras_n = 1'b1;
    logic            cas_n = 1'b1;
    logic            we_n  = 1'b1;
    logic [BA_W-1:0] ba    = '0;
    logic            a10   = 1'b0;
    logic            violation;
    logic [2:0]      reason;
    logic [NB*3-1:0] bank_state;
    logic            dpd_active;

    int errors   = 0;
    int checks   = 0;
    int cycles   = 0;
    bit finished = 0;

    int m_st  [NB];
    int m_rem [NB];
    bit m_dpd = 0;

    sdram_cmd_checker #(
        .NUM_BANKS (NB),
        .T_RP      (T_RP),
        .T_RCD     (T_RCD),
        .BURST_LEN (BL)
    ) u_sdram_cmd_checker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .ba         (ba),
        .a10        (a10),
        .violation  (violation),
        .reason     (reason),
        .bank_state (bank_state),
        .dpd_active (dpd_active)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, got %0d cycles, expected under 20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Reference model: applies one sampled edge, returns expected reason.
    task automatic model(input bit k, input bit c, input bit r, input bit ca, input bit w,
                         input int b, input bit a, output int er);
        bit changed [NB];
        bit all_idle = 1;
        bit any_close = 0;
        bit any_opening = 0;
        int s;
        int code;
        er = 0;
        for (int i = 0; i < NB; i++) begin
            changed[i] = 0;
            if (m_st[i] != S_IDLE)    all_idle    = 0;
            if (m_st[i] == S_CLOSING) any_close   = 1;
            if (m_st[i] == S_OPENING) any_opening = 1;
        end
        s = m_st[b];
        if (m_dpd) begin
            if (k) m_dpd = 0;
        end else if (!k) begin
            if (!c && r && ca && !w) begin
                if (all_idle) m_dpd = 1;
                else er = 4;
            end
        end else if (!c) begin
            code = {29'd0, r, ca, w};
            case (code)
                3: begin
                    if (s == S_IDLE) begin
                        m_st[b] = S_OPENING; m_rem[b] = T_RCD - 1; changed[b] = 1;
                    end else if (s == S_CLOSING) er = 2;
                    else er = 1;
                end
                4, 5: begin
                    if (s == S_OPEN || s == S_READ || s == S_WRITE) begin
                        m_st[b] = (code == 5) ? S_READ : S_WRITE; m_rem[b] = BL - 1; changed[b] = 1;
                    end else if (s == S_OPENING) er = 3;
                    else er = 1;
                end
                2: begin
                    if (a ? any_opening : (s == S_OPENING)) er = 1;
                    else begin
                        for (int i = 0; i < NB; i++) begin
                            if ((a || i == b) &&
                                (m_st[i] == S_OPEN || m_st[i] == S_READ || m_st[i] == S_WRITE)) begin
                                m_st[i] = S_CLOSING; m_rem[i] = T_RP - 1; changed[i] = 1;
                            end
                        end
                    end
                end
                0, 1: begin
                    if (!all_idle) er = any_close ? 2 : 1;
                end
                6: begin
                    if (s == S_READ || s == S_WRITE) begin
                        m_st[b] = S_OPEN; m_rem[b] = 0; changed[b] = 1;
                    end else er = 1;
                end
                default: ;
            endcase
        end
        for (int i = 0; i < NB; i++) begin
            if (!changed[i] && m_st[i] != S_IDLE && m_st[i] != S_OPEN) begin
                if (m_rem[i] <= 1) begin
                    m_st[i]  = (m_st[i] == S_CLOSING) ? S_IDLE : S_OPEN;
                    m_rem[i] = 0;
                end else m_rem[i] = m_rem[i] - 1;
            end
        end
    endtask

    task automatic step(input bit k, input bit c, input bit r, input bit ca, input bit w,
                        input int b, input bit a, input string tag);
        int er;
        logic [NB*3-1:0] eb;
        @(negedge clk);
        cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b[BA_W-1:0]; a10 = a;
        model(k, c, r, ca, w, b, a, er);
        for (int i = 0; i < NB; i++) eb[i*3 +: 3] = 3'(m_st[i]);
        @(posedge clk);
        #1;
        checks++;
        if (violation !== (er != 0) || reason !== 3'(er) || bank_state !== eb || dpd_active !== m_dpd) begin
            errors++;
            $display("FAIL %s: got viol=%0b reason=%0d banks=%h dpd=%0b, expected viol=%0b reason=%0d banks=%h dpd=%0b",
                     tag, violation, reason, bank_state, dpd_active, (er != 0), er, eb, m_dpd);
        end
    endtask

    task automatic nop(input string t);         step(1, 0, 1, 1, 1, 0, 0, t); endtask
    task automatic inhibit(input string t);     step(1, 1, 0, 0, 0, 0, 0, t); endtask
    task automatic act(input int b, input string t);  step(1, 0, 0, 1, 1, b, 0, t); endtask
    task automatic rd(input int b, input string t);   step(1, 0, 1, 0, 1, b, 0, t); endtask
    task automatic wr(input int b, input string t);   step(1, 0, 1, 0, 0, b, 0, t); endtask
    task automatic pre(input int b, input string t);  step(1, 0, 0, 1, 0, b, 0, t); endtask
    task automatic preall(input string t);      step(1, 0, 0, 1, 0, 0, 1, t); endtask
    task automatic refr(input string t);        step(1, 0, 0, 0, 1, 0, 0, t); endtask
    task automatic lmr(input string t);         step(1, 0, 0, 0, 0, 0, 0, t); endtask
    task automatic bst(input int b, input string t);  step(1, 0, 1, 1, 0, b, 0, t); endtask
    task automatic dpd_in(input string t);      step(0, 0, 1, 1, 0, 0, 0, t); endtask

    initial begin
        for (int i = 0; i < NB; i++) begin m_st[i] = S_IDLE; m_rem[i] = 0; end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (violation !== 1'b0 || reason !== 3'd0 || bank_state !== '0 || dpd_active !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset: got viol=%0b reason=%0d banks=%h dpd=%0b, expected 0 0 0 0",
                     violation, reason, bank_state, dpd_active);
        end
        @(negedge clk);
        rst_n = 1'b1;

        inhibit("R1"); nop("R1");
        rd(0, "R2"); wr(1, "R2"); bst(2, "R2"); pre(3, "R2");
        refr("R9"); lmr("R9");

        act(0, "R3"); rd(0, "R3"); rd(0, "R4");
        act(0, "R5"); nop("R7"); nop("R7"); nop("R7");
        act(0, "R4");
        wr(0, "R4"); rd(0, "R6"); wr(0, "R5"); bst(0, "R6");
        wr(0, "R6"); bst(0, "R6"); rd(0, "R5"); bst(0, "R5");
        wr(0, "R6"); pre(0, "R6"); act(0, "R8"); nop("R8"); act(0, "R8"); nop("R8");
        rd(0, "R4"); pre(0, "R5"); nop("R8"); nop("R8");

        act(1, "R3"); nop("R3"); pre(1, "R4");
        refr("R9"); nop("R8"); nop("R8");
        act(2, "R3"); nop("R3"); refr("R9"); lmr("R9");
        act(3, "R3"); preall("R8"); nop("R12");
        preall("R8"); dpd_in("R10"); nop("R8"); nop("R8");
        dpd_in("R10");
        step(0, 0, 0, 1, 1, 1, 0, "R11");
        step(0, 1, 1, 1, 1, 0, 0, "R11");
        step(1, 0, 0, 1, 1, 1, 0, "R11");
        act(1, "R11");
        step(0, 0, 1, 0, 1, 1, 0, "R11");
        step(0, 0, 0, 1, 0, 1, 0, "R11");
        nop("R7"); pre(1, "R8"); nop("R8"); nop("R8"); nop("R8");

        for (int n = 0; n < 600; n++) begin
            int sel;
            int b;
            sel = $urandom_range(0, 11);
            b   = $urandom_range(0, NB - 1);
            case (sel)
                0:  act(b, "R3");
                1:  rd(b, "R5");
                2:  wr(b, "R6");
                3:  pre(b, "R8");
                4:  preall("R8");
                5:  bst(b, "R5");
                6:  refr("R9");
                7:  lmr("R9");
                8:  dpd_in("R10");
                9:  step(0, 0, 0, 1, 1, b, 0, "R11");
                10: inhibit("R1");
                default: nop("R7");
            endcase
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule